// File: doc/BRIEF.md
# USB Dual-Rate Bit Clock Recovery Loop

This block recovers bit timing from a received USB differential data bit using only a fast reference clock. The reference is nominally 48 MHz and may deviate by up to ±0.25%. One phase counter serves both line rates. At full speed a bit cell lasts 4 reference cycles, which gives a 12 MHz bit timing. At low speed a cell lasts 32 cycles, which gives 1.5 MHz. Every data transition the loop observes restarts the counter, so the sample point comes back to the middle of the cell. Between transitions the counter runs freely at the nominal cell length.

The receive bit first passes through a multi-stage synchronizer, and transitions are detected on the synchronized level. The block produces a one-cycle sample strobe and, beside it, a registered copy of the bit it sampled. A downstream NRZI decoder and bit unstuffer consume these two outputs. When the speed select changes, the loop drops back to its idle phase and starts counting cells at the new rate.

Top module: `usb_bitclk_recover`

## Requirements
- R1: While `rst_n` is low, `bit_stb` and `bit_val` are both 0.
- R2: With `ls_mode` = 0 (full speed) and no transition on `rx_diff`, consecutive `bit_stb` pulses are exactly 4 clock cycles apart.
- R3: With `ls_mode` = 1 (low speed) and no transition on `rx_diff`, consecutive `bit_stb` pulses are exactly 32 clock cycles apart.
- R4: Suppose `rx_diff` takes a new level that is first captured at rising edge n. Then `bit_stb` is high in the cycle after edge n+H+2, and low in the cycles after edges n+2 through n+H+1. H is half the cell length of the active speed: 2 at full speed, 16 at low speed. This holds even when the new transition arrives in the middle of a cell.
- R5: At each strobe, `bit_val` carries the `rx_diff` level of the cell being sampled. When a stream is driven with cells of the nominal length, the i-th strobe after the first transition carries the i-th bit.
- R6: `bit_stb` is never high in two consecutive cycles. Each cell of a nominal-length stream yields exactly one strobe.
- R7: Suppose `ls_mode` differs, at rising edge n, from the speed in use. Then `bit_stb` is low in the cycles after edges n through n+H, and high in the cycle after edge n+H+1. Here H is the half-cell length of the new speed.
- R8: `bit_val` changes only in cycles in which `bit_stb` is high.
- R9: After a transition, a run of seven identical cells still yields one strobe per cell, at the nominal spacing, at both speeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, nominally 48 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_mode | input | 1 | Speed select: 0 = full speed (4-cycle cells), 1 = low speed (32-cycle cells) |
| rx_diff | input | 1 | Received differential data bit, asynchronous to `clk` |
| bit_stb | output | 1 | One-cycle sample strobe, asserted near mid-cell |
| bit_val | output | 1 | Bit sampled at the latest strobe, held in between |

## Verification
The bench builds the block with its defaults: cells of 4 and 32 cycles and a two-stage synchronizer. With these values every strobe position in the requirements lands on a fixed, countable cycle after the driving clock edge. An eight-cell low-speed stream also fits in a few hundred cycles, so both rates can be exercised with real bit patterns. Seven-cell runs of one level and a mid-cell early transition are both short enough to test. The two-stage synchronizer fixes the transition-to-strobe latency at H+2 edges, which the realignment and speed-change checks rely on.

// File: rtl/usb_dpll_pkg.sv
package usb_dpll_pkg;

   typedef enum logic {
      SPD_FULL = 1'b0,
      SPD_LOW  = 1'b1
   } spd_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/usb_dpll_sync.sv
module usb_dpll_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/usb_dpll_edge.sv
module usb_dpll_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic hit
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign hit = lvl ^ lvl_q;
endmodule

// File: rtl/usb_dpll_phase.sv
module usb_dpll_phase
   import usb_dpll_pkg::*;
#(
   parameter int FS_DIV = 4,
   parameter int LS_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ls_sel,
   input  logic edge_hit,
   output logic spd_chg,
   output logic spd_low,
   output logic mid_hit
);
   localparam int CW = $clog2(max2(FS_DIV, LS_DIV));
   localparam logic [CW-1:0] FS_LAST = CW'(FS_DIV - 1);
   localparam logic [CW-1:0] LS_LAST = CW'(LS_DIV - 1);
   localparam logic [CW-1:0] FS_MID  = CW'(FS_DIV / 2);
   localparam logic [CW-1:0] LS_MID  = CW'(LS_DIV / 2);

   spd_e          spd_q;
   logic [CW-1:0] phase_q;
   logic [CW-1:0] last_ph;
   logic [CW-1:0] mid_ph;

   always_comb begin
      spd_chg = (spd_e'(ls_sel) != spd_q);
      last_ph = (spd_q == SPD_LOW) ? LS_LAST : FS_LAST;
      mid_ph  = (spd_q == SPD_LOW) ? LS_MID  : FS_MID;
      mid_hit = (phase_q == mid_ph) && !edge_hit && !spd_chg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spd_q   <= SPD_FULL;
         phase_q <= '0;
      end else if (spd_chg) begin
         spd_q   <= spd_e'(ls_sel);
         phase_q <= '0;
      end else if (edge_hit) begin
         phase_q <= CW'(1);
      end else if (phase_q == last_ph) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + CW'(1);
      end
   end

   assign spd_low = (spd_q == SPD_LOW);
endmodule

// File: rtl/usb_bitclk_recover.sv
module usb_bitclk_recover #(
   parameter int FS_DIV      = 4,
   parameter int LS_DIV      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ls_mode,
   input  logic rx_diff,
   output logic bit_stb,
   output logic bit_val
);
   generate
      if (FS_DIV < 4 || (FS_DIV % 2) != 0) begin : g_bad_fs
         $error("FS_DIV must be even and at least 4");
      end
      if (LS_DIV <= FS_DIV || (LS_DIV % 2) != 0) begin : g_bad_ls
         $error("LS_DIV must be even and larger than FS_DIV");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic rx_lvl;
   logic edge_hit;
   logic spd_chg;
   logic spd_low;
   logic mid_hit;

   usb_dpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_diff),
      .q     (rx_lvl)
   );

   usb_dpll_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (rx_lvl),
      .hit   (edge_hit)
   );

   usb_dpll_phase #(.FS_DIV(FS_DIV), .LS_DIV(LS_DIV)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .ls_sel   (ls_mode),
      .edge_hit (edge_hit),
      .spd_chg  (spd_chg),
      .spd_low  (spd_low),
      .mid_hit  (mid_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_stb <= 1'b0;
         bit_val <= 1'b0;
      end else begin
         bit_stb <= mid_hit;
         if (mid_hit) bit_val <= rx_lvl;
      end
   end
endmodule

// File: rtl/usb_bitclk_recover_chk.sv
module usb_bitclk_recover_chk #(
   parameter int FS_DIV = 4,
   parameter int LS_DIV = 32
) (
   input logic clk,
   input logic rst_n,
   input logic bit_stb,
   input logic bit_val,
   input logic edge_hit,
   input logic spd_chg,
   input logic spd_low
);
   logic [15:0] gap;
   logic        seen;
   logic        clean;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap   <= '0;
         seen  <= 1'b0;
         clean <= 1'b0;
      end else if (bit_stb) begin
         gap   <= 16'd1;
         seen  <= 1'b1;
         clean <= !(edge_hit || spd_chg);
      end else begin
         if (gap != 16'hFFFF) gap <= gap + 16'd1;
         if (edge_hit || spd_chg) clean <= 1'b0;
      end
   end

   // R1: outputs held low in reset
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!bit_stb && !bit_val);
      end
   end

   // R2: full-speed free-run spacing
   assert_fs_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && seen && clean && !spd_low) |-> (gap == 16'(FS_DIV)));

   // R3: low-speed free-run spacing
   assert_ls_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && seen && clean && spd_low) |-> (gap == 16'(LS_DIV)));

   // R6: strobe lasts one cycle
   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);

   // R7: a speed change suppresses the next strobe
   assert_speed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      spd_chg |=> !bit_stb);

   // R8: sampled bit holds between strobes
   assert_val_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |-> $stable(bit_val));
endmodule

bind usb_bitclk_recover usb_bitclk_recover_chk #(
   .FS_DIV (FS_DIV),
   .LS_DIV (LS_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_stb  (bit_stb),
   .bit_val  (bit_val),
   .edge_hit (edge_hit),
   .spd_chg  (spd_chg),
   .spd_low  (spd_low)
);

// File: tb/usb_bitclk_recover_bench.sv
module usb_bitclk_recover_bench;
   localparam int FS_P = 4;
   localparam int LS_P = 32;
   localparam int FS_H = FS_P / 2;
   localparam int LS_H = LS_P / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ls_mode = 1'b0;
   logic rx_diff = 1'b0;
   logic bit_stb;
   logic bit_val;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   usb_bitclk_recover u_usb_bitclk_recover (
      .clk     (clk),
      .rst_n   (rst_n),
      .ls_mode (ls_mode),
      .rx_diff (rx_diff),
      .bit_stb (bit_stb),
      .bit_val (bit_val)
   );

   task automatic chk(input logic ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         rx_diff = i[0];
         chk(bit_stb == 1'b0, "R1", "bit_stb in reset", int'(bit_stb), 0);
         chk(bit_val == 1'b0, "R1", "bit_val in reset", int'(bit_val), 0);
      end
      rx_diff = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   // drives n cells of length per, checks strobe position, value and quiet gaps
   task automatic t_cells(input logic [7:0] pat, input int n, input int per,
                          input int hlf, input string req);
      int extra;
      int holdbad;
      logic pv;
      extra = 0;
      holdbad = 0;
      @(negedge clk);
      rx_diff = pat[0];
      pv = bit_val;
      for (int t = 1; t <= n * per + 2; t++) begin
         int rel;
         @(negedge clk);
         rel = t - (hlf + 3);
         if (rel >= 0 && (rel % per) == 0 && (rel / per) < n) begin
            chk(bit_stb == 1'b1, req, $sformatf("strobe of cell %0d (R4)", rel / per),
                int'(bit_stb), 1);
            chk(bit_val == pat[rel / per], "R5", $sformatf("value of cell %0d", rel / per),
                int'(bit_val), int'(pat[rel / per]));
         end else if (t >= 3 && bit_stb) begin
            extra++;
         end
         if (!bit_stb && bit_val != pv) holdbad++;
         pv = bit_val;
         if ((t % per) == 0 && (t / per) < n) rx_diff = pat[t / per];
      end
      chk(extra == 0, "R6", "strobes outside cell centres", extra, 0);
      chk(holdbad == 0, "R8", "bit_val changes without strobe", holdbad, 0);
   endtask

   task automatic t_speed(input logic to_ls, input int hlf);
      int extra;
      extra = 0;
      @(negedge clk);
      ls_mode = to_ls;
      for (int t = 1; t <= hlf + 2; t++) begin
         @(negedge clk);
         if (t == hlf + 2) chk(bit_stb == 1'b1, "R7", "first strobe after speed change",
                               int'(bit_stb), 1);
         else if (bit_stb) extra++;
      end
      chk(extra == 0, "R7", "strobes during speed restart", extra, 0);
   endtask

   // low speed: transition in mid cell pulls the phase along (R4)
   task automatic t_ls_early();
      int extra;
      logic lvl;
      extra = 0;
      lvl = ~rx_diff;
      @(negedge clk);
      rx_diff = lvl;
      for (int t = 1; t <= 40; t++) begin
         @(negedge clk);
         if (t == LS_H + 3) begin
            chk(bit_stb == 1'b1, "R4", "strobe before early edge", int'(bit_stb), 1);
            chk(bit_val == lvl, "R5", "value before early edge", int'(bit_val), int'(lvl));
         end else if (t == 20 + LS_H + 3) begin
            chk(bit_stb == 1'b1, "R4", "strobe after early edge", int'(bit_stb), 1);
            chk(bit_val == ~lvl, "R5", "value after early edge", int'(bit_val), int'(~lvl));
         end else if (t >= 23 && bit_stb) begin
            extra++;
         end
         if (t == 20) rx_diff = ~lvl;
      end
      chk(extra == 0, "R4", "old-phase strobes after early edge", extra, 0);
   endtask

   initial begin
      t_reset();
      t_cells(8'b1011_1001, 8, FS_P, FS_H, "R2");
      t_cells(8'h00, 8, FS_P, FS_H, "R9");
      t_speed(1'b1, LS_H);
      t_cells(8'b1000_1011, 8, LS_P, LS_H, "R3");
      t_cells(8'h00, 8, LS_P, LS_H, "R9");
      t_ls_early();
      repeat (40) @(negedge clk);
      t_speed(1'b0, FS_H);
      t_cells(8'b0110_1101, 8, FS_P, FS_H, "R2");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule